// File: doc/BRIEF.md
# Status Field to Condition Field Move Unit

This block keeps a 32-bit floating-point status and control word and an eight-field condition word with four bits per field. Its one operation takes a nibble of the status word, chosen by a source index, and copies it into a condition field chosen by a destination index. In the same step it clears the sticky exception flags that lie inside the chosen nibble. Every other bit of that nibble is left alone, so control bits such as the rounding mode survive the read. The two derived summary bits, invalid-operation summary and enabled-exception summary, are then rebuilt from the whole word.

The command port is single-cycle: valid, source index and destination index. When the floating-point unit is disabled, a command changes no state and raises a one-cycle exception request. A generic status write port stands in for the arithmetic that would set the flags. It and a condition write port, together with the read ports, give test access to both words.

Status bits are numbered big-endian. Status bit n sits at vector index 31-n. Field k covers status bits 4k..4k+3, which is vector slice [31-4k -: 4]. The condition word uses the same field placement.

Top module: `fsc_move_unit`

## Requirements
- R1: After reset, st_rdata and cr_rdata are zero and exc_req is low.
- R2: An accepted command (cmd_valid=1, fpu_en=1) with source k and destination d writes st_rdata[31-4k -: 4], as it stood before the command, into cr_rdata[31-4d -: 4]. All other condition fields keep their values.
- R3: Sticky flags are the status vector indices 31, 28, 27, 26, 25, 24, 23, 22, 21, 20, 19, 10, 9 and 8. An accepted command clears only those sticky flags that lie inside the source field.
- R4: Every non-sticky bit of the source field keeps its value after the command, except bits 30 and 29. This includes the rounding-mode bits [1:0] when field 7 is read.
- R5: After an accepted command, bit 29 (VX) equals the OR of vector indices 24..19 and 10..8. Bit 30 (FEX) equals (VX&[7]) | ([28]&[6]) | ([27]&[5]) | ([26]&[4]) | ([25]&[3]). Both are computed on the cleared word, so they drop to 0 when no contributor remains, even when the source field is not field 0.
- R6: Reading field 0 delivers the FX, FEX and VX values from before the clear into the condition field.
- R7: A command issued while fpu_en=0 changes neither word. exc_req is high for exactly the next cycle. At all other times exc_req is low.
- R8: When an accepted command and st_we coincide, the status write is dropped. When an accepted command and cr_we coincide, cr_wdata loads every condition field except the destination field, which takes the moved nibble.
- R9: Without an accepted command, st_we loads st_wdata verbatim and cr_we loads cr_wdata. All updates are visible on the read ports in the cycle after the edge that commits them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fpu_en | input | 1 | Floating-point unit enabled |
| cmd_valid | input | 1 | Move command strobe |
| cmd_src | input | 3 | Source status field index |
| cmd_dst | input | 3 | Destination condition field index |
| exc_req | output | 1 | Unavailable-unit exception request |
| st_we | input | 1 | Generic status write enable |
| st_wdata | input | 32 | Generic status write data |
| st_rdata | output | 32 | Status word read port |
| cr_we | input | 1 | Condition word write enable |
| cr_wdata | input | 32 | Condition word write data |
| cr_rdata | output | 32 | Condition word read port |

## Verification
The bench uses the default configuration of eight four-bit fields. This is small enough to sweep every source and destination pair, all 64 of them, under six status patterns. The patterns include all-ones, all-zero, only the sticky flags, summaries set with nothing behind them, and two mixed words. Together they reach the field-0 pre-clear read, the rounding-mode survival in field 7, and summary collapse from fields far from bits 30 and 29. Directed cases add the disabled unit and the collisions between a command and each write port.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
   localparam int REG_W = 32;

   // vector indices (big-endian bit n at index 31-n)
   localparam int I_FX     = 31;
   localparam int I_FEX    = 30;
   localparam int I_VX     = 29;
   localparam int I_OX     = 28;
   localparam int I_UX     = 27;
   localparam int I_ZX     = 26;
   localparam int I_XX     = 25;
   localparam int I_VE     = 7;
   localparam int I_OE     = 6;
   localparam int I_UE     = 5;
   localparam int I_ZE     = 4;
   localparam int I_XE     = 3;

   // flags that a field read clears
   localparam logic [REG_W-1:0] STICKY_MASK   = 32'h9FF8_0700;
   // invalid-operation causes feeding VX
   localparam logic [REG_W-1:0] VX_CAUSE_MASK = 32'h01F8_0700;
endpackage

// File: rtl/fsc_field_pick.sv
module fsc_field_pick
   import fsc_pkg::*;
#(
   parameter int N_FIELDS = 8,
   parameter int FIELD_W  = 4,
   localparam int IDX_W   = $clog2(N_FIELDS)
) (
   input  logic [REG_W-1:0]   reg_i,
   input  logic [IDX_W-1:0]   idx_i,
   output logic [FIELD_W-1:0] nib_o,
   output logic [REG_W-1:0]   mask_o
);
   logic [FIELD_W-1:0] nibs  [N_FIELDS];
   logic [REG_W-1:0]   masks [N_FIELDS];

   for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
      localparam int TOP = REG_W - 1 - g * FIELD_W;
      assign nibs[g]  = reg_i[TOP -: FIELD_W];
      assign masks[g] = {{FIELD_W{1'b1}}, {(REG_W-FIELD_W){1'b0}}} >> (g * FIELD_W);
   end

   assign nib_o  = nibs[idx_i];
   assign mask_o = masks[idx_i];
endmodule

// File: rtl/fsc_summary.sv
module fsc_summary
   import fsc_pkg::*;
(
   input  logic [REG_W-1:0] raw_i,
   output logic [REG_W-1:0] fixed_o
);
   logic vx;

   always_comb begin
      vx      = |(raw_i & VX_CAUSE_MASK);
      fixed_o = raw_i;
      fixed_o[I_VX]  = vx;
      fixed_o[I_FEX] = (vx & raw_i[I_VE])
                     | (raw_i[I_OX] & raw_i[I_OE])
                     | (raw_i[I_UX] & raw_i[I_UE])
                     | (raw_i[I_ZX] & raw_i[I_ZE])
                     | (raw_i[I_XX] & raw_i[I_XE]);
   end
endmodule

// File: rtl/fsc_cond_file.sv
module fsc_cond_file
   import fsc_pkg::*;
#(
   parameter int N_FIELDS = 8,
   parameter int FIELD_W  = 4,
   localparam int IDX_W   = $clog2(N_FIELDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bulk_we,
   input  logic [REG_W-1:0]   bulk_wdata,
   input  logic               fld_we,
   input  logic [IDX_W-1:0]   fld_idx,
   input  logic [FIELD_W-1:0] fld_data,
   output logic [REG_W-1:0]   rdata
);
   for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
      localparam int TOP = REG_W - 1 - g * FIELD_W;
      logic [FIELD_W-1:0] q;
      logic               hit;
      assign hit = fld_we && (fld_idx == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)       q <= '0;
         else if (hit)     q <= fld_data;
         else if (bulk_we) q <= bulk_wdata[TOP -: FIELD_W];
      end
      assign rdata[TOP -: FIELD_W] = q;
   end
endmodule

// File: rtl/fsc_move_unit.sv
module fsc_move_unit
   import fsc_pkg::*;
#(
   parameter int N_FIELDS = 8,
   parameter int FIELD_W  = 4,
   localparam int IDX_W   = $clog2(N_FIELDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fpu_en,
   input  logic               cmd_valid,
   input  logic [IDX_W-1:0]   cmd_src,
   input  logic [IDX_W-1:0]   cmd_dst,
   output logic               exc_req,
   input  logic               st_we,
   input  logic [REG_W-1:0]   st_wdata,
   output logic [REG_W-1:0]   st_rdata,
   input  logic               cr_we,
   input  logic [REG_W-1:0]   cr_wdata,
   output logic [REG_W-1:0]   cr_rdata
);
   if (N_FIELDS * FIELD_W != REG_W) begin : g_bad_geom
      $error("field geometry must tile the 32-bit status word");
   end
   if ((1 << IDX_W) != N_FIELDS) begin : g_bad_idx
      $error("field count must be a power of two");
   end

   logic [REG_W-1:0]   status_q;
   logic               exc_q;
   logic               cmd_go;
   logic [FIELD_W-1:0] pick_nib;
   logic [REG_W-1:0]   pick_mask;
   logic [REG_W-1:0]   cleared;
   logic [REG_W-1:0]   moved;

   assign cmd_go  = cmd_valid & fpu_en;
   assign cleared = status_q & ~(pick_mask & STICKY_MASK);

   fsc_field_pick #(.N_FIELDS(N_FIELDS), .FIELD_W(FIELD_W)) u_pick (
      .reg_i  (status_q),
      .idx_i  (cmd_src),
      .nib_o  (pick_nib),
      .mask_o (pick_mask)
   );

   fsc_summary u_sum (
      .raw_i   (cleared),
      .fixed_o (moved)
   );

   fsc_cond_file #(.N_FIELDS(N_FIELDS), .FIELD_W(FIELD_W)) u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .bulk_we    (cr_we),
      .bulk_wdata (cr_wdata),
      .fld_we     (cmd_go),
      .fld_idx    (cmd_dst),
      .fld_data   (pick_nib),
      .rdata      (cr_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         exc_q    <= 1'b0;
      end else begin
         exc_q <= cmd_valid & ~fpu_en;
         if (cmd_go)     status_q <= moved;
         else if (st_we) status_q <= st_wdata;
      end
   end

   assign st_rdata = status_q;
   assign exc_req  = exc_q;
endmodule

// File: rtl/fsc_move_unit_chk.sv
module fsc_move_unit_chk
   import fsc_pkg::*;
#(
   parameter int N_FIELDS = 8,
   parameter int FIELD_W  = 4,
   localparam int IDX_W   = $clog2(N_FIELDS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fpu_en,
   input logic             cmd_valid,
   input logic [IDX_W-1:0] cmd_src,
   input logic [IDX_W-1:0] cmd_dst,
   input logic             exc_req,
   input logic             st_we,
   input logic [REG_W-1:0] st_rdata,
   input logic [REG_W-1:0] cr_rdata
);
   function automatic logic [FIELD_W-1:0] nib(input logic [REG_W-1:0] v, input logic [IDX_W-1:0] i);
      logic [REG_W-1:0] s;
      s = v >> (FIELD_W * (N_FIELDS - 1 - int'(i)));
      return s[FIELD_W-1:0];
   endfunction

   function automatic logic [REG_W-1:0] fmask(input logic [IDX_W-1:0] i);
      return {{FIELD_W{1'b1}}, {(REG_W-FIELD_W){1'b0}}} >> (FIELD_W * int'(i));
   endfunction

   a_r2_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && fpu_en) |=> nib(cr_rdata, $past(cmd_dst)) == nib($past(st_rdata), $past(cmd_src)));

   a_r3_sticky_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && fpu_en) |=> (st_rdata & fmask($past(cmd_src)) & STICKY_MASK) == '0);

   a_r5_vx_summary: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && fpu_en) |=> st_rdata[I_VX] == |(st_rdata & VX_CAUSE_MASK));

   a_r7_exc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !fpu_en) |=> exc_req);

   a_r7_exc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && !fpu_en) |=> !exc_req);

   a_r7_no_update: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !fpu_en && !st_we) |=> $stable(st_rdata));
endmodule

bind fsc_move_unit fsc_move_unit_chk #(.N_FIELDS(N_FIELDS), .FIELD_W(FIELD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fpu_en    (fpu_en),
   .cmd_valid (cmd_valid),
   .cmd_src   (cmd_src),
   .cmd_dst   (cmd_dst),
   .exc_req   (exc_req),
   .st_we     (st_we),
   .st_rdata  (st_rdata),
   .cr_rdata  (cr_rdata)
);

// File: tb/test_fsc_move_unit.sv
`timescale 1ns/1ps
module test_fsc_move_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fpu_en = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_src = '0;
   logic [2:0]  cmd_dst = '0;
   logic        exc_req;
   logic        st_we = 1'b0;
   logic [31:0] st_wdata = '0;
   logic [31:0] st_rdata;
   logic        cr_we = 1'b0;
   logic [31:0] cr_wdata = '0;
   logic [31:0] cr_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fsc_move_unit i_fsc_move_unit (
      .clk(clk), .rst_n(rst_n), .fpu_en(fpu_en), .cmd_valid(cmd_valid),
      .cmd_src(cmd_src), .cmd_dst(cmd_dst), .exc_req(exc_req),
      .st_we(st_we), .st_wdata(st_wdata), .st_rdata(st_rdata),
      .cr_we(cr_we), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata)
   );

   // big-endian status bit numbers
   int sticky_be [14] = '{0, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 21, 22, 23};
   int vxc_be    [9]  = '{7, 8, 9, 10, 11, 12, 21, 22, 23};

   function automatic logic [3:0] nib(input logic [31:0] v, input int f);
      return v[31-4*f -: 4];
   endfunction

   function automatic logic [31:0] put(input logic [31:0] v, input int f, input logic [3:0] n);
      logic [31:0] r;
      r = v;
      r[31-4*f -: 4] = n;
      return r;
   endfunction

   function automatic logic bit_be(input logic [31:0] v, input int be);
      return v[31-be];
   endfunction

   function automatic logic [31:0] exp_status(input logic [31:0] s, input int f);
      logic [31:0] r;
      logic vx, fex;
      r = s;
      foreach (sticky_be[i]) if (sticky_be[i] / 4 == f) r[31-sticky_be[i]] = 1'b0;
      vx = 1'b0;
      foreach (vxc_be[i]) vx = vx | bit_be(r, vxc_be[i]);
      fex = (vx & bit_be(r, 24)) | (bit_be(r, 3) & bit_be(r, 25)) | (bit_be(r, 4) & bit_be(r, 26))
          | (bit_be(r, 5) & bit_be(r, 27)) | (bit_be(r, 6) & bit_be(r, 28));
      r[31-2] = vx;
      r[31-1] = fex;
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic load(input logic [31:0] st, input logic [31:0] cr);
      @(negedge clk);
      st_we = 1'b1; st_wdata = st; cr_we = 1'b1; cr_wdata = cr;
      @(negedge clk);
      st_we = 1'b0; cr_we = 1'b0;
   endtask

   logic [31:0] pats [6] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h9FF8_0700,
                             32'h6000_00FF, 32'h1234_5678, 32'hDEAD_BEEF};

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 status reset", st_rdata, 32'h0);
      chk("R1 cond reset", cr_rdata, 32'h0);
      chk("R1 exc reset", {31'b0, exc_req}, 32'h0);
      rst_n = 1'b1;

      // R9 plain writes
      load(32'hA5C3_0F11, 32'h0123_4567);
      chk("R9 status write", st_rdata, 32'hA5C3_0F11);
      chk("R9 cond write", cr_rdata, 32'h0123_4567);

      // full sweep: R2 R3 R4 R5 R6
      foreach (pats[p]) begin
         for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 8; d++) begin
               logic [31:0] bg;
               bg = pats[p] ^ 32'h5A5A_5A5A ^ {8{d[3:0]}};
               load(pats[p], bg);
               cmd_valid = 1'b1; cmd_src = 3'(s); cmd_dst = 3'(d);
               @(negedge clk);
               cmd_valid = 1'b0;
               chk(s == 0 ? "R2 R6 cond field0" : "R2 cond field",
                   cr_rdata, put(bg, d, nib(pats[p], s)));
               chk(s == 7 ? "R3 R4 R5 status field7" : "R3 R4 R5 status",
                   st_rdata, exp_status(pats[p], s));
               chk("R7 exc quiet", {31'b0, exc_req}, 32'h0);
            end
         end
      end

      // R7 disabled unit
      load(32'hFFFF_FFFF, 32'h1111_2222);
      fpu_en = 1'b0; cmd_valid = 1'b1; cmd_src = 3'd1; cmd_dst = 3'd5;
      @(negedge clk);
      cmd_valid = 1'b0; fpu_en = 1'b1;
      chk("R7 exc pulse", {31'b0, exc_req}, 32'h1);
      chk("R7 status kept", st_rdata, 32'hFFFF_FFFF);
      chk("R7 cond kept", cr_rdata, 32'h1111_2222);
      @(negedge clk);
      chk("R7 exc one cycle", {31'b0, exc_req}, 32'h0);

      // R9 disabled command does not block a status write
      fpu_en = 1'b0; cmd_valid = 1'b1; st_we = 1'b1; st_wdata = 32'h0BAD_F00D;
      @(negedge clk);
      cmd_valid = 1'b0; st_we = 1'b0; fpu_en = 1'b1;
      chk("R9 write with disabled cmd", st_rdata, 32'h0BAD_F00D);

      // R8 collisions
      load(32'h9FF8_07FF, 32'h0);
      cmd_valid = 1'b1; cmd_src = 3'd2; cmd_dst = 3'd3;
      st_we = 1'b1; st_wdata = 32'h0000_0000;
      cr_we = 1'b1; cr_wdata = 32'hCCCC_CCCC;
      @(negedge clk);
      cmd_valid = 1'b0; st_we = 1'b0; cr_we = 1'b0;
      chk("R8 status write dropped", st_rdata, exp_status(32'h9FF8_07FF, 2));
      chk("R8 cond merge", cr_rdata, put(32'hCCCC_CCCC, 3, nib(32'h9FF8_07FF, 2)));

      // R4 rounding mode survives repeated field-7 reads
      load(32'h0000_0002, 32'h0);
      for (int k = 0; k < 2; k++) begin
         cmd_valid = 1'b1; cmd_src = 3'd7; cmd_dst = 3'd7;
         @(negedge clk);
         cmd_valid = 1'b0;
         chk("R4 rounding kept", st_rdata, 32'h0000_0002);
         chk("R4 rounding read", cr_rdata, 32'h0000_0002);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule